// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block is a 32-bit arithmetic unit whose operations clip their result at a range limit instead of wrapping around. An opcode picks the operation. Signed and unsigned add and subtract clip at the word range. Signed doubling multiplies by two and clips. Saturation to a programmable bit position works in a signed or an unsigned form, and each form also has a dual-halfword variant that treats the two 16-bit halves as separate values. One more opcode performs a plain wrapping add and only reports signed overflow.

Whenever an operation has to clip, a sticky saturation flag is set. The flag then stays high whatever operations follow, until the dedicated clear input is driven. The result and the flag are both registered, so each appears one clock after its operands are sampled. A host uses the unit as a datapath slice: it drives operands and an opcode every cycle, and it reads and clears the flag at the end of a sequence of operations.

Top module: `satu_top`

## Requirements
- R1: Opcode 0 (signed add) and opcode 1 (signed subtract) return the wrapped result unless signed overflow occurs. An add overflows when both operands share a sign and the sum has the other sign. A subtract overflows when the operands differ in sign and the difference's sign differs from operand A. On overflow the result is 0x7FFFFFFF if A is non-negative and 0x80000000 if A is negative.
- R2: Opcode 2 (signed doubling of A) returns 0x7FFFFFFF when A, read as signed, is at least 0x40000000. It returns 0x80000000 when A is at most 0xC0000000. Any other A gives A shifted left by one.
- R3: Opcode 3 (unsigned add) returns 0xFFFFFFFF when the sum carries out. Opcode 4 (unsigned subtract) returns 0 when B is greater than A. Otherwise both return the plain result.
- R4: Opcode 5 (signed saturate A to position n = shift input) arithmetic-shifts A right by n. If that quotient is positive the result is 2^n-1. If the quotient is below -1 the result is the bitwise complement of 2^n-1. Otherwise A passes unchanged.
- R5: Opcode 6 (unsigned saturate A to position n) returns 0 for a negative A and 2^n-1 for an A above 2^n-1. Otherwise A passes unchanged.
- R6: Opcodes 7 and 8 apply the R4 and R5 rules, in that order, to each signed 16-bit half of A on its own. The low half's 16-bit result goes in bits 15:0 and the high half's in bits 31:16. The flag is set if either half clips.
- R7: Opcode 9 (flag-only add) always returns the wrapped sum A+B and counts as clipping only when the R1 add overflow condition holds.
- R8: Every clipping event in R1 to R7 sets the saturation flag. Once set, the flag stays set through any sequence of operations while the clear input is low.
- R9: The clear input drives the flag to 0 on the next edge, even when the same cycle's operation clips. Reset also leaves the flag at 0.
- R10: The result and the flag update on the clock edge after the inputs are sampled, and they hold their values between edges. Reset makes the result 0.
- R11: Opcodes 10 to 15 are no-ops: the result becomes 0 and the flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation select (0 to 9 valid, 10 to 15 no-op) |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| shamt_i | input | 5 | Saturation bit position n |
| sat_clr_i | input | 1 | Clear the sticky saturation flag |
| result_o | output | 32 | Registered result |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
On every cycle, the assertions check how the flag is kept: the clear wins over a set, a set flag stays set, a clip always sets the flag and the flag never rises without one. They also check that no-op opcodes give a zero result and that a clipped signed or unsigned add gives one of its limit values. The exact clipped values still need the bench's scenarios. These are the doubling thresholds at 0x40000000 and 0xC0000000, the behaviour of positions 0 and 31, the passing of a quotient of -1, and the case where one halfword clips while the other does not. The bench also checks the one-cycle latency, the reset values, and a flag that stays set across a long run of non-clipping operations.

// File: rtl/satu_pkg.sv
// Package satu_pkg
// Holds the opcode encoding shared by every module of the saturating unit.
// Assumes a 4-bit opcode field. Codes above OPC_ADDQ are no-ops.
package satu_pkg;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_SADD   = 4'd0;
    localparam logic [OPC_W-1:0] OPC_SSUB   = 4'd1;
    localparam logic [OPC_W-1:0] OPC_SDBL   = 4'd2;
    localparam logic [OPC_W-1:0] OPC_UADD   = 4'd3;
    localparam logic [OPC_W-1:0] OPC_USUB   = 4'd4;
    localparam logic [OPC_W-1:0] OPC_SSAT   = 4'd5;
    localparam logic [OPC_W-1:0] OPC_USAT   = 4'd6;
    localparam logic [OPC_W-1:0] OPC_SSAT16 = 4'd7;
    localparam logic [OPC_W-1:0] OPC_USAT16 = 4'd8;
    localparam logic [OPC_W-1:0] OPC_ADDQ   = 4'd9;
endpackage

// File: rtl/satu_arith.sv
// Module satu_arith
// Combinational add/subtract/doubling datapath with clipping.
// Covers signed add, signed subtract, signed doubling, unsigned add,
// unsigned subtract and the flag-only add. For any other opcode it
// returns zero and reports no clip. Assumes DATA_W >= 3.
module satu_arith
    import satu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OPC_W-1:0]  op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              clip
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W:0]   usum_w;
    logic [DATA_W:0]   udiff_w;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] diff;
    logic              carry;
    logic              borrow;
    logic              add_ovf;
    logic              sub_ovf;
    logic [DATA_W-1:0] signed_lim;
    logic              dbl_hi;
    logic              dbl_lo;

    // Widened sums expose the unsigned carry and borrow.
    always_comb begin
        usum_w  = {1'b0, a} + {1'b0, b};
        udiff_w = {1'b0, a} - {1'b0, b};
        sum     = usum_w[DATA_W-1:0];
        diff    = udiff_w[DATA_W-1:0];
        carry   = usum_w[DATA_W];
        borrow  = udiff_w[DATA_W];
    end

    // Signed overflow rules and the limit chosen from A's sign.
    always_comb begin
        add_ovf    = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
        sub_ovf    = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
        signed_lim = a[MSB] ? S_MIN : S_MAX;
    end

    // Doubling thresholds: A >= 2^(W-2) or A <= -2^(W-2).
    always_comb begin
        dbl_hi = !a[MSB] && a[MSB-1];
        dbl_lo = a[MSB] && (!a[MSB-1] || (a[MSB-2:0] == '0));
    end

    // Result select per opcode.
    always_comb begin
        res  = '0;
        clip = 1'b0;
        case (op)
            OPC_SADD: begin
                clip = add_ovf;
                res  = add_ovf ? signed_lim : sum;
            end
            OPC_SSUB: begin
                clip = sub_ovf;
                res  = sub_ovf ? signed_lim : diff;
            end
            OPC_SDBL: begin
                clip = dbl_hi || dbl_lo;
                if (dbl_hi)      res = S_MAX;
                else if (dbl_lo) res = S_MIN;
                else             res = {a[MSB-1:0], 1'b0};
            end
            OPC_UADD: begin
                clip = carry;
                res  = carry ? '1 : sum;
            end
            OPC_USUB: begin
                clip = borrow;
                res  = borrow ? '0 : diff;
            end
            OPC_ADDQ: begin
                clip = add_ovf;
                res  = sum;
            end
            default: begin
                res  = '0;
                clip = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/satu_clip.sv
// Module satu_clip
// Saturates a W-bit value to bit position n, in signed or unsigned form.
// Signed: the quotient val >>> n chooses +(2^n-1), ~(2^n-1) or passes val.
// Unsigned: a negative val gives 0, and val above 2^n-1 gives 2^n-1.
// Assumes a position of W or more makes the limit all ones, which
// passes every in-range value.
module satu_clip #(
    parameter int W    = 32,
    parameter int SH_W = 5
) (
    input  logic [W-1:0]    val,
    input  logic [SH_W-1:0] shamt,
    input  logic            sgn,
    output logic [W-1:0]    res,
    output logic            clip
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] limit;
    logic [W-1:0] quot;
    logic         q_pos;
    logic         q_low;

    // Limit 2^n-1 and the arithmetic quotient val >>> n.
    always_comb begin
        limit = (ONE << shamt) - ONE;
        quot  = W'($signed(val) >>> shamt);
        q_pos = !quot[W-1] && (quot != '0);
        q_low = quot[W-1] && (quot != '1);
    end

    // Pick the saturated value for the chosen form.
    always_comb begin
        res  = val;
        clip = 1'b0;
        if (sgn) begin
            if (q_pos) begin
                res  = limit;
                clip = 1'b1;
            end else if (q_low) begin
                res  = ~limit;
                clip = 1'b1;
            end
        end else begin
            if (val[W-1]) begin
                res  = '0;
                clip = 1'b1;
            end else if (val > limit) begin
                res  = limit;
                clip = 1'b1;
            end
        end
    end
endmodule

// File: rtl/satu_top.sv
// Module satu_top
// Saturating arithmetic unit with a sticky saturation flag.
// The add/sub path, one word-wide clip lane and HALVES halfword clip lanes
// work in parallel. The opcode selects one result into the output register.
// Any clip sets the flag, and only clear or reset lowers it. Clear wins.
// Assumes DATA_W is even and a power of two. Reset is synchronous, active low.
module satu_top
    import satu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [OPC_W-1:0]          op_i,
    input  logic [DATA_W-1:0]         a_i,
    input  logic [DATA_W-1:0]         b_i,
    input  logic [$clog2(DATA_W)-1:0] shamt_i,
    input  logic                      sat_clr_i,
    output logic [DATA_W-1:0]         result_o,
    output logic                      sat_flag_o
);
    localparam int HALVES  = 2;
    localparam int HALF_W  = DATA_W / HALVES;
    localparam int SHAMT_W = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] arith_res;
    logic              arith_clip;
    logic [DATA_W-1:0] word_res;
    logic              word_clip;
    logic [DATA_W-1:0] lane_pack;
    logic [HALVES-1:0] lane_clip;
    logic [DATA_W-1:0] next_res;
    logic              clip_any;

    satu_arith #(.DATA_W(DATA_W)) u_arith (
        .op   (op_i),
        .a    (a_i),
        .b    (b_i),
        .res  (arith_res),
        .clip (arith_clip)
    );

    satu_clip #(.W(DATA_W), .SH_W(SHAMT_W)) u_word_clip (
        .val   (a_i),
        .shamt (shamt_i),
        .sgn   (op_i == OPC_SSAT),
        .res   (word_res),
        .clip  (word_clip)
    );

    for (genvar g = 0; g < HALVES; g++) begin : g_lane
        logic [HALF_W-1:0] l_res;
        logic              l_clip;

        satu_clip #(.W(HALF_W), .SH_W(SHAMT_W)) u_half_clip (
            .val   (a_i[g*HALF_W +: HALF_W]),
            .shamt (shamt_i),
            .sgn   (op_i == OPC_SSAT16),
            .res   (l_res),
            .clip  (l_clip)
        );

        assign lane_pack[g*HALF_W +: HALF_W] = l_res;
        assign lane_clip[g]                  = l_clip;
    end

    // Choose the result and the clip indication for the current opcode.
    always_comb begin
        case (op_i)
            OPC_SSAT, OPC_USAT: begin
                next_res = word_res;
                clip_any = word_clip;
            end
            OPC_SSAT16, OPC_USAT16: begin
                next_res = lane_pack;
                clip_any = |lane_clip;
            end
            default: begin
                next_res = arith_res;
                clip_any = arith_clip;
            end
        endcase
    end

    // Output register for the selected result.
    always_ff @(posedge clk) begin
        if (!rst_n) result_o <= '0;
        else        result_o <= next_res;
    end

    // Sticky flag: clear has priority, any clip sets it, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         sat_flag_o <= 1'b0;
        else if (sat_clr_i) sat_flag_o <= 1'b0;
        else if (clip_any)  sat_flag_o <= 1'b1;
    end

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sat_clr_i |=> !sat_flag_o);

    a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_clr_i && sat_flag_o) |=> sat_flag_o);

    a_r8_clip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_clr_i && clip_any) |=> sat_flag_o);

    a_r8_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag_o) |-> $past(clip_any));

    a_r11_noop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > OPC_ADDQ) |=> (result_o == '0));

    a_r3_uadd_clip_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_UADD && arith_clip) |=> (result_o == '1));

    a_r1_sadd_clip_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_SADD && arith_clip) |=> (result_o == S_MAX || result_o == S_MIN));
endmodule

// File: tb/tb_satu_top.sv
`timescale 1ns/1ps
module tb_satu_top;
    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  sh;
        logic [31:0] exp;
        logic        clip;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b1},
        '{4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0,  32'h80000000, 1'b1},
        '{4'd0, 32'h00000005, 32'h00000007, 5'd0,  32'h0000000C, 1'b0},
        '{4'd1, 32'h80000000, 32'h00000001, 5'd0,  32'h80000000, 1'b1},
        '{4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0,  32'h7FFFFFFF, 1'b1},
        '{4'd1, 32'h0000000A, 32'h00000003, 5'd0,  32'h00000007, 1'b0},
        '{4'd2, 32'h40000000, 32'h0,        5'd0,  32'h7FFFFFFF, 1'b1},
        '{4'd2, 32'h3FFFFFFF, 32'h0,        5'd0,  32'h7FFFFFFE, 1'b0},
        '{4'd2, 32'hC0000000, 32'h0,        5'd0,  32'h80000000, 1'b1},
        '{4'd2, 32'hC0000001, 32'h0,        5'd0,  32'h80000002, 1'b0},
        '{4'd3, 32'hFFFFFFF0, 32'h00000020, 5'd0,  32'hFFFFFFFF, 1'b1},
        '{4'd3, 32'h00000001, 32'h00000002, 5'd0,  32'h00000003, 1'b0},
        '{4'd4, 32'h00000003, 32'h00000005, 5'd0,  32'h00000000, 1'b1},
        '{4'd4, 32'h00000005, 32'h00000003, 5'd0,  32'h00000002, 1'b0},
        '{4'd5, 32'h0000012C, 32'h0,        5'd8,  32'h000000FF, 1'b1},
        '{4'd5, 32'hFFFFFED4, 32'h0,        5'd8,  32'hFFFFFF00, 1'b1},
        '{4'd5, 32'h00000064, 32'h0,        5'd8,  32'h00000064, 1'b0},
        '{4'd5, 32'hFFFFFF80, 32'h0,        5'd7,  32'hFFFFFF80, 1'b0},
        '{4'd5, 32'h00000001, 32'h0,        5'd0,  32'h00000000, 1'b1},
        '{4'd6, 32'hFFFFFFFF, 32'h0,        5'd8,  32'h00000000, 1'b1},
        '{4'd6, 32'h00000100, 32'h0,        5'd8,  32'h000000FF, 1'b1},
        '{4'd6, 32'h000000FF, 32'h0,        5'd8,  32'h000000FF, 1'b0},
        '{4'd6, 32'h7FFFFFFF, 32'h0,        5'd31, 32'h7FFFFFFF, 1'b0},
        '{4'd7, 32'h0100FF00, 32'h0,        5'd7,  32'h007FFF80, 1'b1},
        '{4'd7, 32'h00050003, 32'h0,        5'd7,  32'h00050003, 1'b0},
        '{4'd7, 32'h00050200, 32'h0,        5'd8,  32'h000500FF, 1'b1},
        '{4'd8, 32'h80000123, 32'h0,        5'd8,  32'h000000FF, 1'b1},
        '{4'd8, 32'h00100020, 32'h0,        5'd8,  32'h00100020, 1'b0},
        '{4'd9, 32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b1},
        '{4'd9, 32'h00000002, 32'h00000003, 5'd0,  32'h00000005, 1'b0},
        '{4'd9, 32'h80000000, 32'h80000000, 5'd0,  32'h00000000, 1'b1},
        '{4'd15, 32'h00000005, 32'h00000006, 5'd0, 32'h00000000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op_i;
    logic [31:0] a_i;
    logic [31:0] b_i;
    logic [4:0]  shamt_i;
    logic        sat_clr_i;
    logic [31:0] result_o;
    logic        sat_flag_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    satu_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_i),
        .a_i        (a_i),
        .b_i        (b_i),
        .shamt_i    (shamt_i),
        .sat_clr_i  (sat_clr_i),
        .result_o   (result_o),
        .sat_flag_o (sat_flag_o)
    );

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R1";
            4'd2:       return "R2";
            4'd3, 4'd4: return "R3";
            4'd5:       return "R4";
            4'd6:       return "R5";
            4'd7, 4'd8: return "R6";
            4'd9:       return "R7";
            default:    return "R11";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive inputs at a falling edge, then wait one full cycle.
    task automatic step(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                        logic [4:0] sh, logic clr);
        op_i = op; a_i = a; b_i = b; shamt_i = sh; sat_clr_i = clr;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        op_i = 4'd0; a_i = 32'h7FFFFFFF; b_i = 32'h1; shamt_i = '0; sat_clr_i = 1'b0;
        repeat (3) @(negedge clk);
        // R10 and R9: reset state, even while a clipping op is applied
        check("R10 reset result", result_o, 32'h0);
        check("R9 reset flag", {31'b0, sat_flag_o}, 32'h0);
        rst_n = 1'b1;

        // Vector table: clear the flag, then one operation, then compare
        for (int i = 0; i < NV; i++) begin
            step(4'd15, 32'h0, 32'h0, 5'd0, 1'b1);
            step(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sh, 1'b0);
            check({req_of(VECS[i].op), " result"}, result_o, VECS[i].exp);
            check({req_of(VECS[i].op), " flag R8"}, {31'b0, sat_flag_o}, {31'b0, VECS[i].clip});
        end

        // R8: flag stays set across many non-clipping operations
        step(4'd15, 32'h0, 32'h0, 5'd0, 1'b1);
        step(4'd3, 32'hFFFFFFFF, 32'h1, 5'd0, 1'b0);
        for (int k = 0; k < 6; k++) step(4'd0, k, 32'h1, 5'd0, 1'b0);
        check("R8 sticky flag", {31'b0, sat_flag_o}, 32'h1);
        check("R8 result after run", result_o, 32'h6);

        // R11: no-op gives zero and keeps the flag
        step(4'd12, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, 1'b0);
        check("R11 noop result", result_o, 32'h0);
        check("R11 noop flag kept", {31'b0, sat_flag_o}, 32'h1);

        // R9: clear wins over a same-cycle clip, and the result is unaffected
        step(4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1'b1);
        check("R9 clear beats set", {31'b0, sat_flag_o}, 32'h0);
        check("R9 result with clear", result_o, 32'h7FFFFFFF);
        step(4'd4, 32'h0, 32'h1, 5'd0, 1'b0);
        check("R9 set again", {31'b0, sat_flag_o}, 32'h1);
        step(4'd3, 32'h1, 32'h1, 5'd0, 1'b1);
        check("R9 clear of set flag", {31'b0, sat_flag_o}, 32'h0);

        // R10: the output holds until the next rising edge
        step(4'd0, 32'h5, 32'h7, 5'd0, 1'b0);
        op_i = 4'd3; a_i = 32'h1; b_i = 32'h1;
        #1;
        check("R10 holds before edge", result_o, 32'hC);
        @(negedge clk);
        check("R10 updates after edge", result_o, 32'h2);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule